// File: doc/BRIEF.md
# Latched Mouse Interrupt Input

This block sits on interrupt line 12. A configuration bit sets how it behaves. In standard mode it is a plain level-sensitive line: the output tracks the external request pin once that pin has been synchronised. In mouse mode the block waits for a low-to-high transition on the pin and records it as a pending request. It then holds interrupt request 12 asserted toward the interrupt controller until software consumes the event, even after the pin itself drops.

Software consumes the event by reading the keyboard-controller data port at I/O address 0x0060. The block watches an active-low ISA-style read strobe and its 16-bit address. It treats the falling edge of that strobe, with the address matching, as the clearing read. The request pin and the read strobe each pass through a two-stage synchroniser before edges are detected. The address travels through a pipeline of the same depth, so each strobe edge is judged against the address that came with it. If a new rising edge and a clearing read are detected together, the request stays set, so no event is lost.

Top module: `mouse_irq_latch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `irq12Out` is 0 and no request is pending.
- R2: With `mouseMode` = 0, `irq12Out` equals the level of `irqPin` as sampled two rising clock edges earlier (two-flop synchroniser).
- R3: With `mouseMode` = 1, a 0-to-1 change of `irqPin` sets the pending request. `irq12Out` becomes 1 after the third rising clock edge that follows the change.
- R4: With `mouseMode` = 1, a pending request stays asserted when `irqPin` returns to 0 and for as long as no clearing read occurs.
- R5: A falling edge of `iorN` with `ioAddr` = 16'h0060 clears the pending request. `irq12Out` drops after the third rising clock edge that follows the strobe falling.
- R6: A falling edge of `iorN` with any address other than 16'h0060 leaves the pending request untouched.
- R7: Only the falling edge of `iorN` clears. A request set while `iorN` is already held low, or at the moment `iorN` returns high, is kept.
- R8: When a rising pin edge and a clearing read are detected in the same cycle, the request ends up set.
- R9: In standard mode the pending request is held clear. After a switch into mouse mode, `irq12Out` is 0 until a new rising edge arrives, whatever the pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqPin | input | 1 | Raw external interrupt request, asynchronous |
| mouseMode | input | 1 | 1 selects edge-latched mouse behaviour, 0 selects plain level |
| iorN | input | 1 | Active-low I/O read strobe, asynchronous |
| ioAddr | input | 16 | I/O address qualifying the read strobe |
| irq12Out | output | 1 | Interrupt request 12 toward the interrupt controller |

## Verification
The assertions check, on every cycle, the state changes of the request flag. In standard mode it is forced clear. In mouse mode a detected edge sets it, a qualified read without a coincident edge clears it, and without a clearing read it holds. The control strobes are also checked to be mutually exclusive, and the standard-mode output is checked to follow the synchroniser one cycle late. Only the bench scenarios can show the end-to-end latencies from the pins: the three-edge delay for both setting and clearing, address qualification, the held-low strobe case, the coincident event and the mode switch. There, a behavioural reference model is compared with `irq12Out` after every clock.

// File: rtl/mlatch_pkg.sv
package mlatch_pkg;

  localparam int ADDR_W = 16;

  // Events reported by the datapath after synchronisation
  typedef struct packed {
    logic              pinLevel;
    logic              pinRise;
    logic              readFall;
    logic [ADDR_W-1:0] readAddr;
  } mlatch_evt_t;

  // Strobes issued by the control toward the datapath
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic forceClr;
    logic selLatch;
  } mlatch_ctl_t;

endpackage

// File: rtl/mlatch_datapath.sv
module mlatch_datapath
  import mlatch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irqPin,
  input  logic              iorN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  mlatch_ctl_t       ctl,
  output mlatch_evt_t       evt,
  output logic              irq12Out
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]     pinPipe;
  logic [LAST:0]     iorPipe;
  logic [ADDR_W-1:0] addrPipe [SYNC_STAGES];
  logic              pinPrev;
  logic              iorPrev;
  logic              pending;

  // Synchroniser chains for the asynchronous pin and strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinPipe <= '0;
      iorPipe <= '1;
      pinPrev <= 1'b0;
      iorPrev <= 1'b1;
    end else begin
      pinPipe <= {pinPipe[LAST-1:0], irqPin};
      iorPipe <= {iorPipe[LAST-1:0], iorN};
      pinPrev <= pinPipe[LAST];
      iorPrev <= iorPipe[LAST];
    end
  end

  // Address pipeline matching the strobe synchroniser depth
  genvar st;
  generate
    for (st = 0; st < SYNC_STAGES; st++) begin : gAddr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          addrPipe[st] <= '0;
        end else if (st == 0) begin
          addrPipe[st] <= ioAddr;
        end else begin
          addrPipe[st] <= addrPipe[(st == 0) ? 0 : st-1];
        end
      end
    end
  endgenerate

  always_comb begin
    evt.pinLevel = pinPipe[LAST];
    evt.pinRise  = pinPipe[LAST] & ~pinPrev;
    evt.readFall = iorPrev & ~iorPipe[LAST];
    evt.readAddr = addrPipe[LAST];
  end

  // Pending request flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (ctl.forceClr) begin
      pending <= 1'b0;
    end else if (ctl.setLatch) begin
      pending <= 1'b1;
    end else if (ctl.clrLatch) begin
      pending <= 1'b0;
    end
  end

  assign irq12Out = ctl.selLatch ? pending : pinPipe[LAST];

  assert_std_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.forceClr |=> !pending);

  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.setLatch && !ctl.forceClr) |=> pending);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clrLatch |=> !pending);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ctl.clrLatch && !ctl.forceClr) |=> pending);

  assert_std_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.selLatch && SYNC_STAGES == 2) |-> (irq12Out == $past(pinPipe[0])));

endmodule

// File: rtl/mlatch_ctrl.sv
module mlatch_ctrl
  import mlatch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TRIGGER_ADDR = 16'h0060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mouseMode,
  input  mlatch_evt_t evt,
  output mlatch_ctl_t ctl
);

  logic readHit;

  assign readHit = evt.readFall && (evt.readAddr == TRIGGER_ADDR);

  always_comb begin
    ctl.selLatch = mouseMode;
    ctl.forceClr = ~mouseMode;
    ctl.setLatch = mouseMode & evt.pinRise;
    // A coincident edge wins over the clearing read
    ctl.clrLatch = mouseMode & readHit & ~evt.pinRise;
  end

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.setLatch, ctl.clrLatch, ctl.forceClr}));

  assert_miss_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.readAddr != TRIGGER_ADDR) |-> !ctl.clrLatch);

endmodule

// File: rtl/mouse_irq_latch.sv
module mouse_irq_latch
  import mlatch_pkg::*;
#(
  parameter int                SYNC_STAGES  = 2,
  parameter logic [ADDR_W-1:0] TRIGGER_ADDR = 16'h0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irqPin,
  input  logic              mouseMode,
  input  logic              iorN,
  input  logic [ADDR_W-1:0] ioAddr,
  output logic              irq12Out
);

  mlatch_evt_t evt;
  mlatch_ctl_t ctl;

  mlatch_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqPin   (irqPin),
    .iorN     (iorN),
    .ioAddr   (ioAddr),
    .ctl      (ctl),
    .evt      (evt),
    .irq12Out (irq12Out)
  );

  mlatch_ctrl #(.TRIGGER_ADDR(TRIGGER_ADDR)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mouseMode (mouseMode),
    .evt       (evt),
    .ctl       (ctl)
  );

  always_comb begin
    assert_reset_idle_R1: assert (rst_n || !irq12Out);
  end

endmodule

// File: tb/mouse_irq_latch_tb_top.sv
module mouse_irq_latch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irqPin = 1'b0;
  logic        mouseMode = 1'b0;
  logic        iorN = 1'b1;
  logic [15:0] ioAddr = 16'h0000;
  logic        irq12Out;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mouse_irq_latch dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irqPin    (irqPin),
    .mouseMode (mouseMode),
    .iorN      (iorN),
    .ioAddr    (ioAddr),
    .irq12Out  (irq12Out)
  );

  // Behavioural reference: histories of sampled inputs, newest first
  bit        pinH [4];
  bit        iorH [4];
  bit [15:0] addrH [4];
  bit        refPend;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        pinH[i] = 1'b0; iorH[i] = 1'b1; addrH[i] = 16'h0;
      end
      refPend = 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        pinH[i] = pinH[i-1]; iorH[i] = iorH[i-1]; addrH[i] = addrH[i-1];
      end
      pinH[0] = irqPin; iorH[0] = iorN; addrH[0] = ioAddr;
      if (!mouseMode) refPend = 1'b0;
      else if (pinH[2] && !pinH[3]) refPend = 1'b1;
      else if (!iorH[2] && iorH[3] && addrH[2] == 16'h0060) refPend = 1'b0;
    end
  end

  task automatic check(input bit actual, input bit expected, input string tag);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: irq12Out=%0b expected %0b at %0t", tag, actual, expected, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (mouseMode) check(irq12Out, refPend, "R3/R5 model");
      else           check(irq12Out, pinH[1], "R2 model");
    end
  end

  task automatic edgeChk(input int n, input bit expected, input string tag);
    repeat (n) @(posedge clk);
    #1;
    check(irq12Out, expected, tag);
  endtask

  task automatic drive(input bit pin, input bit ior, input bit [15:0] addr);
    @(negedge clk);
    irqPin = pin; iorN = ior; ioAddr = addr;
  endtask

  initial begin
    // R1: reset behaviour with active pin and mouse mode
    mouseMode = 1'b1;
    irqPin = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(irq12Out, 1'b0, "R1 during reset");
    @(negedge clk); irqPin = 1'b0; rst_n = 1'b1;
    edgeChk(1, 1'b0, "R1 after release");
    edgeChk(3, 1'b0, "R1 idle");

    // R2: standard mode level tracking
    @(negedge clk); mouseMode = 1'b0;
    drive(1'b1, 1'b1, 16'h0);
    edgeChk(1, 1'b0, "R2 one edge");
    edgeChk(1, 1'b1, "R2 two edges");
    drive(1'b0, 1'b1, 16'h0);
    edgeChk(2, 1'b0, "R2 low");

    // R9: edge seen in standard mode, then switch while pin high
    drive(1'b1, 1'b1, 16'h0);
    edgeChk(4, 1'b1, "R2 high");
    @(negedge clk); mouseMode = 1'b1;
    edgeChk(1, 1'b0, "R9 no carried request");
    edgeChk(3, 1'b0, "R9 still clear");

    // R3: rising edge latches after three edges
    drive(1'b0, 1'b1, 16'h0);
    edgeChk(3, 1'b0, "R3 pin low");
    drive(1'b1, 1'b1, 16'h0);
    edgeChk(2, 1'b0, "R3 before latency");
    edgeChk(1, 1'b1, "R3 latched");
    // R4: holds after pin drops
    drive(1'b0, 1'b1, 16'h0);
    edgeChk(5, 1'b1, "R4 held");

    // R6: read of another address
    drive(1'b0, 1'b0, 16'h0064);
    edgeChk(5, 1'b1, "R6 other port");
    drive(1'b0, 1'b1, 16'h0064);
    edgeChk(3, 1'b1, "R6 strobe released");

    // R5: read of 0x0060 clears on the falling strobe
    drive(1'b0, 1'b0, 16'h0060);
    edgeChk(2, 1'b1, "R5 before latency");
    edgeChk(1, 1'b0, "R5 cleared");

    // R7: set while strobe held low, then strobe released
    drive(1'b1, 1'b0, 16'h0060);
    edgeChk(3, 1'b1, "R7 set under low strobe");
    drive(1'b0, 1'b0, 16'h0060);
    edgeChk(3, 1'b1, "R7 held low strobe");
    drive(1'b0, 1'b1, 16'h0060);
    edgeChk(4, 1'b1, "R7 release no clear");

    // R8: coincident edge and clearing read
    drive(1'b1, 1'b0, 16'h0060);
    edgeChk(3, 1'b1, "R8 coincident");
    edgeChk(3, 1'b1, "R8 stays set");
    drive(1'b0, 1'b1, 16'h0060);
    drive(1'b0, 1'b0, 16'h0060);
    edgeChk(3, 1'b0, "R5 second clear");
    drive(1'b0, 1'b1, 16'h0);
    edgeChk(4, 1'b0, "R4 clear holds");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule